// File: doc/BRIEF.md
# Clock Select Register Bank

This block holds the divider-ratio and clock-multiplexer select words of a clock control unit. Software reaches it over a plain 32-bit register bus and the block drives the selected values to the divider and multiplexer hardware. Each word is split into fields. The top bit of every field is a per-field write enable, so software can change one field with a single write and leave the other fields in that word alone. Bits that belong to no field are never stored.

The main bus-clock dividers sit in registers 9 and 10, and they are updated in two stages. A write to either register changes only a pending copy, and a read returns that pending copy. The dividers keep running from the active copy until software writes a change request to register 11. Register 11 reads 1 while the request is in progress. After a fixed, parameterised number of cycles the pending values become active and the request clears itself. Registers 1 and 8 have no pending stage: a write to them reaches the outputs at once.

Top module: `cselBank`

## Requirements
- R1: After reset the registers read 0x00000001 (register 1), 0x00000000 (register 8), 0x0033338F (register 9), 0x00000099 (register 10) and 0 (register 11). The active outputs equal these values.
- R2: Register n sits at byte offset 4*(n-1). Address bits [1:0] are ignored. Offsets that hold no register read zero, and writes to them change nothing.
- R3: A field stores its part of the written data only when the field's most significant bit is 1 in that data. A field whose enable bit is 0 keeps its old value, even when other fields in the same write are updated.
- R4: Bits that lie outside every field read 0 and cannot be set by any write.
- R5: Register 1 has fields at bits 0..2, 3..7, 8..12, 13..17, 18..21, 22..28 and 28..30. Bit 28 is shared: it takes the written bit when either field that covers it is enabled (enable bit 28 or enable bit 30).
- R6: Register 1 has fields as stated in R5. Register 8 has a single field at bits 3..5. A write to register 1 or 8 shows on the active outputs right after the clock edge that accepts it.
- R7: Register 9 has fields at bits 0..6, 7..11, 12..15, 16..19 and 20..23. Register 10 has fields at bits 0..2, 3..6 and 7..9. Writes to registers 9 and 10 change only the pending value that reads return. The active outputs stay unchanged until a change request completes.
- R8: Writing data with bit 0 set to register 11 (offset 0x28) while no request is in progress starts a request. Register 11 then reads 1 for exactly UPDATE_CYCLES cycles, after which it reads 0. On that same edge the active outputs of registers 9 and 10 take their pending values.
- R9: A request write made while a request is already in progress is ignored and does not extend the request. A write to register 11 with bit 0 clear starts nothing.
- R10: Pending writes to registers 9 and 10 made while a request is in progress are included in the values that request applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrEn | input | 1 | Write strobe, sampled on the rising clock edge |
| busAddr | input | ADDR_W | Byte address of the access |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for busAddr (combinational) |
| activeSel1 | output | 32 | Active word of register 1 |
| activeSel8 | output | 32 | Active word of register 8 |
| activeDiv9 | output | 32 | Active word of register 9 |
| activeDiv10 | output | 32 | Active word of register 10 |

## Verification
The hardest situation to reach is a second request and a fresh pending write arriving while a request is still counting. Both must fold into that request's commit without moving its end edge. The bench starts a request, then three edges later writes the request register again and rewrites a field of register 10. It then checks that register 11 is still set one edge before the expected end and clear exactly at UPDATE_CYCLES, and that the newest pending value is the one applied. The shared bit 28 in register 1 is the other awkward case. It is reached with two writes that each enable only one of the two covering fields.

// File: rtl/cselPkg.sv
package cselPkg;

  localparam int WORD_W      = 32;
  localparam int MAX_FIELDS  = 7;
  localparam int NUM_SLOTS   = 4;
  localparam int REQ_REG_NUM = 11;

  typedef struct packed {
    logic [4:0] lsb;
    logic [4:0] width;
  } fieldT;

  typedef fieldT [MAX_FIELDS-1:0] layoutT;

  typedef struct packed {
    logic [NUM_SLOTS-1:0] slotWr;
    logic                 commit;
  } strobeT;

  // register number held by each storage slot
  function automatic int slotRegNum(input int s);
    case (s)
      0:       return 1;
      1:       return 8;
      2:       return 9;
      default: return 10;
    endcase
  endfunction

  // slots whose values pass through a pending stage
  function automatic bit slotStaged(input int s);
    return (s >= 2);
  endfunction

  function automatic logic [WORD_W-1:0] slotReset(input int s);
    case (s)
      0:       return 32'h0000_0001;
      1:       return 32'h0000_0000;
      2:       return 32'h0033_338F;
      default: return 32'h0000_0099;
    endcase
  endfunction

  function automatic layoutT slotLayout(input int s);
    layoutT lay;
    lay = '0;
    case (s)
      0: begin
        lay[0] = '{5'd0,  5'd3};
        lay[1] = '{5'd3,  5'd5};
        lay[2] = '{5'd8,  5'd5};
        lay[3] = '{5'd13, 5'd5};
        lay[4] = '{5'd18, 5'd4};
        lay[5] = '{5'd22, 5'd7};
        lay[6] = '{5'd28, 5'd3};
      end
      1: lay[0] = '{5'd3, 5'd3};
      2: begin
        lay[0] = '{5'd0,  5'd7};
        lay[1] = '{5'd7,  5'd5};
        lay[2] = '{5'd12, 5'd4};
        lay[3] = '{5'd16, 5'd4};
        lay[4] = '{5'd20, 5'd4};
      end
      default: begin
        lay[0] = '{5'd0, 5'd3};
        lay[1] = '{5'd3, 5'd4};
        lay[2] = '{5'd7, 5'd3};
      end
    endcase
    return lay;
  endfunction

  // bits covered by one field
  function automatic logic [WORD_W-1:0] fieldBits(input fieldT f);
    logic [WORD_W-1:0] m;
    m = '0;
    for (int b = 0; b < WORD_W; b++) begin
      if (b >= int'(f.lsb) && b < int'(f.lsb) + int'(f.width)) m[b] = 1'b1;
    end
    return m;
  endfunction

  // union of all fields of a layout
  function automatic logic [WORD_W-1:0] spanMask(input layoutT lay);
    logic [WORD_W-1:0] m;
    m = '0;
    for (int f = 0; f < MAX_FIELDS; f++) m |= fieldBits(lay[f]);
    return m;
  endfunction

  // bits a write may change: fields whose top bit is set in the data
  function automatic logic [WORD_W-1:0] writeMask(input layoutT lay,
                                                  input logic [WORD_W-1:0] data);
    logic [WORD_W-1:0] m;
    int top;
    m = '0;
    for (int f = 0; f < MAX_FIELDS; f++) begin
      if (lay[f].width != 5'd0) begin
        top = int'(lay[f].lsb) + int'(lay[f].width) - 1;
        if (data[top]) m |= fieldBits(lay[f]);
      end
    end
    return m;
  endfunction

endpackage

// File: rtl/cselRegSlot.sv
module cselRegSlot
  import cselPkg::*;
#(
  parameter layoutT             LAYOUT    = '0,
  parameter logic [WORD_W-1:0]  RESET_VAL = '0,
  parameter bit                 STAGED    = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [WORD_W-1:0] wrData,
  input  logic              commit,
  output logic [WORD_W-1:0] shownWord,
  output logic [WORD_W-1:0] activeWord
);

  localparam logic [WORD_W-1:0] SPAN = spanMask(LAYOUT);

  logic [WORD_W-1:0] heldQ;
  logic [WORD_W-1:0] updMask;

  assign updMask = writeMask(LAYOUT, wrData);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     heldQ <= RESET_VAL;
    else if (wrEn) heldQ <= (heldQ & ~updMask) | (wrData & updMask);
  end

  assign shownWord = heldQ;

  generate
    if (STAGED) begin : g_staged
      logic [WORD_W-1:0] liveQ;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)       liveQ <= RESET_VAL;
        else if (commit) liveQ <= heldQ;
      end

      assign activeWord = liveQ;

      a_r7_active_waits_commit: assert property (@(posedge clk) disable iff (!rstN)
        !commit |=> $stable(activeWord));

      a_r8_commit_takes_pending: assert property (@(posedge clk) disable iff (!rstN)
        commit |=> (activeWord == $past(shownWord)));
    end else begin : g_direct
      logic unusedCommit;
      assign unusedCommit = commit;
      assign activeWord   = heldQ;
    end
  endgenerate

  a_r3_hold_without_write: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> $stable(shownWord));

  a_r4_no_stray_bits: assert property (@(posedge clk) disable iff (!rstN)
    (shownWord & ~SPAN) == '0);

endmodule

// File: rtl/cselCtrl.sv
module cselCtrl
  import cselPkg::*;
#(
  parameter int ADDR_W        = 8,
  parameter int UPDATE_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-3:0] wordIdx,
  input  logic              reqBit,
  output strobeT            strobes,
  output logic              busy
);

  localparam int IDX_W = ADDR_W - 2;
  localparam int CNT_W = $clog2(UPDATE_CYCLES + 1);

  logic [NUM_SLOTS-1:0] hitVec;
  logic                 reqHit;
  logic                 startReq;
  logic                 busyQ;
  logic [CNT_W-1:0]     cntQ;

  generate
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_decode
      assign hitVec[s] = busWrEn && (wordIdx == IDX_W'(slotRegNum(s) - 1));
    end
  endgenerate

  assign reqHit   = busWrEn && reqBit && (wordIdx == IDX_W'(REQ_REG_NUM - 1));
  assign startReq = reqHit && !busyQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      cntQ  <= '0;
    end else if (startReq) begin
      busyQ <= 1'b1;
      cntQ  <= CNT_W'(UPDATE_CYCLES - 1);
    end else if (busyQ) begin
      if (cntQ == '0) busyQ <= 1'b0;
      else            cntQ  <= cntQ - 1'b1;
    end
  end

  always_comb begin
    strobes.slotWr = hitVec;
    strobes.commit = busyQ && (cntQ == '0);
  end

  assign busy = busyQ;

  // independent run-length counter for the request window
  logic [CNT_W-1:0] busyRun;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                   busyRun <= '0;
    else if (!busyQ)                             busyRun <= '0;
    else if (busyRun != CNT_W'(UPDATE_CYCLES))   busyRun <= busyRun + 1'b1;
  end

  a_r8_window_bounded: assert property (@(posedge clk) disable iff (!rstN)
    busyQ |-> (busyRun < CNT_W'(UPDATE_CYCLES)));

  a_r9_full_window: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busyQ) |-> ($past(busyRun) == CNT_W'(UPDATE_CYCLES - 1)));

  a_r8_commit_ends_request: assert property (@(posedge clk) disable iff (!rstN)
    strobes.commit |=> !busyQ);

endmodule

// File: rtl/cselDatapath.sv
module cselDatapath
  import cselPkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  strobeT                          strobes,
  input  logic [WORD_W-1:0]               wrData,
  input  logic [ADDR_W-3:0]               wordIdx,
  input  logic                            busy,
  output logic [WORD_W-1:0]               rdData,
  output logic [NUM_SLOTS-1:0][WORD_W-1:0] activeWords
);

  localparam int IDX_W = ADDR_W - 2;

  logic [NUM_SLOTS-1:0][WORD_W-1:0] shownWords;

  generate
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      cselRegSlot #(
        .LAYOUT   (slotLayout(s)),
        .RESET_VAL(slotReset(s)),
        .STAGED   (slotStaged(s))
      ) u_slot (
        .clk       (clk),
        .rstN      (rstN),
        .wrEn      (strobes.slotWr[s]),
        .wrData    (wrData),
        .commit    (strobes.commit),
        .shownWord (shownWords[s]),
        .activeWord(activeWords[s])
      );
    end
  endgenerate

  always_comb begin
    rdData = '0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      if (wordIdx == IDX_W'(slotRegNum(s) - 1)) rdData = shownWords[s];
    end
    if (wordIdx == IDX_W'(REQ_REG_NUM - 1)) rdData = {{(WORD_W-1){1'b0}}, busy};
  end

  a_r8_commit_only_when_busy: assert property (@(posedge clk) disable iff (!rstN)
    strobes.commit |-> busy);

  a_r2_one_slot_per_write: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobes.slotWr));

endmodule

// File: rtl/cselBank.sv
module cselBank
  import cselPkg::*;
#(
  parameter int ADDR_W        = 8,
  parameter int UPDATE_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWrData,
  output logic [31:0]       busRdData,
  output logic [31:0]       activeSel1,
  output logic [31:0]       activeSel8,
  output logic [31:0]       activeDiv9,
  output logic [31:0]       activeDiv10
);

  logic [ADDR_W-3:0]                 wordIdx;
  logic [1:0]                        unusedLowAddr;
  strobeT                            strobes;
  logic                              busy;
  logic [NUM_SLOTS-1:0][WORD_W-1:0]  activeWords;

  assign wordIdx       = busAddr[ADDR_W-1:2];
  assign unusedLowAddr = busAddr[1:0];

  cselCtrl #(
    .ADDR_W       (ADDR_W),
    .UPDATE_CYCLES(UPDATE_CYCLES)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .busWrEn(busWrEn),
    .wordIdx(wordIdx),
    .reqBit (busWrData[0]),
    .strobes(strobes),
    .busy   (busy)
  );

  cselDatapath #(
    .ADDR_W(ADDR_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .wrData     (busWrData),
    .wordIdx    (wordIdx),
    .busy       (busy),
    .rdData     (busRdData),
    .activeWords(activeWords)
  );

  assign activeSel1  = activeWords[0];
  assign activeSel8  = activeWords[1];
  assign activeDiv9  = activeWords[2];
  assign activeDiv10 = activeWords[3];

endmodule

// File: tb/cselBank_tb.sv
module cselBank_tb;

  localparam int ADDR_W   = 8;
  localparam int UPD      = 8;
  localparam int WATCHDOG = 20000;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              busWrEn = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [31:0]       busWrData = '0;
  logic [31:0]       busRdData;
  logic [31:0]       activeSel1, activeSel8, activeDiv9, activeDiv10;

  int checkCount = 0;
  int failCount  = 0;

  always #4 clk = ~clk;

  cselBank #(.ADDR_W(ADDR_W), .UPDATE_CYCLES(UPD)) u_dut (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData),
    .activeSel1(activeSel1), .activeSel8(activeSel8),
    .activeDiv9(activeDiv9), .activeDiv10(activeDiv10)
  );

  task automatic checkEq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wrReg(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0; busWrData = '0;
  endtask

  task automatic rdReg(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdData;
  endtask

  task automatic testReset();
    logic [31:0] v;
    rdReg(8'h00, v); checkEq("R1 reg1 reset", v, 32'h0000_0001);
    rdReg(8'h1C, v); checkEq("R1 reg8 reset", v, 32'h0000_0000);
    rdReg(8'h20, v); checkEq("R1 reg9 reset", v, 32'h0033_338F);
    rdReg(8'h24, v); checkEq("R1 reg10 reset", v, 32'h0000_0099);
    rdReg(8'h28, v); checkEq("R1 request reset", v, 32'h0);
    checkEq("R1 active9 reset", activeDiv9, 32'h0033_338F);
    checkEq("R1 active10 reset", activeDiv10, 32'h0000_0099);
    checkEq("R1 active1 reset", activeSel1, 32'h0000_0001);
  endtask

  task automatic testAddressing();
    logic [31:0] v;
    wrReg(8'h04, 32'hFFFF_FFFF);
    rdReg(8'h04, v); checkEq("R2 unmapped reads zero", v, 32'h0);
    rdReg(8'h00, v); checkEq("R2 unmapped write no effect", v, 32'h0000_0001);
    rdReg(8'h2C, v); checkEq("R2 offset 0x2C zero", v, 32'h0);
    wrReg(8'h1F, 32'h0000_0038);
    rdReg(8'h1C, v); checkEq("R2 low address bits ignored", v, 32'h0000_0038);
  endtask

  task automatic testFieldEnables();
    logic [31:0] v;
    wrReg(8'h1C, 32'h0000_0018);
    rdReg(8'h1C, v); checkEq("R3 enable clear keeps field", v, 32'h0000_0038);
    wrReg(8'h1C, 32'h0000_0020);
    rdReg(8'h1C, v); checkEq("R3 enable set updates field", v, 32'h0000_0020);
    checkEq("R6 reg8 output follows write", activeSel8, 32'h0000_0020);
    wrReg(8'h1C, 32'hFFFF_FFC7);
    rdReg(8'h1C, v); checkEq("R4 stray bits not stored", v, 32'h0000_0020);
    wrReg(8'h1C, 32'hFFFF_FFFF);
    rdReg(8'h1C, v); checkEq("R4 only field bits kept", v, 32'h0000_0038);
  endtask

  task automatic testPackedWord();
    logic [31:0] v;
    wrReg(8'h00, 32'h1000_0000);
    rdReg(8'h00, v); checkEq("R5 bit28 via low field", v, 32'h1000_0001);
    wrReg(8'h00, 32'h4000_0000);
    rdReg(8'h00, v); checkEq("R5 bit28 via top field", v, 32'h4000_0001);
    wrReg(8'h00, 32'h0000_0004);
    checkEq("R6 reg1 output follows write", activeSel1, 32'h4000_0004);
  endtask

  task automatic testStagedHold();
    logic [31:0] v;
    wrReg(8'h20, 32'h00A0_0040);
    rdReg(8'h20, v); checkEq("R3 reg9 mixed enables", v, 32'h00A3_33C0);
    checkEq("R7 active9 unchanged", activeDiv9, 32'h0033_338F);
    wrReg(8'h20, 32'hFF00_0000);
    rdReg(8'h20, v); checkEq("R4 reg9 upper bits dropped", v, 32'h00A3_33C0);
    wrReg(8'h24, 32'h0000_0207);
    rdReg(8'h24, v); checkEq("R7 reg10 pending", v, 32'h0000_021F);
    waitCycles(3);
    checkEq("R7 active10 unchanged", activeDiv10, 32'h0000_0099);
  endtask

  task automatic testCommitTiming();
    logic [31:0] v;
    wrReg(8'h28, 32'h1);
    for (int i = 0; i < UPD; i++) begin
      rdReg(8'h28, v); checkEq("R8 request reads one", v, 32'h1);
      checkEq("R8 active9 before end", activeDiv9, 32'h0033_338F);
      waitCycles(1);
    end
    rdReg(8'h28, v); checkEq("R8 request cleared", v, 32'h0);
    checkEq("R8 active9 applied", activeDiv9, 32'h00A3_33C0);
    checkEq("R8 active10 applied", activeDiv10, 32'h0000_021F);
  endtask

  task automatic testBusyIgnore();
    logic [31:0] v;
    wrReg(8'h28, 32'h2);
    rdReg(8'h28, v); checkEq("R9 bit0 clear starts nothing", v, 32'h0);
    wrReg(8'h28, 32'h1);
    waitCycles(2);
    wrReg(8'h28, 32'h1);
    wrReg(8'h24, 32'h0000_0004);
    waitCycles(UPD - 5);
    rdReg(8'h28, v); checkEq("R9 still busy before end", v, 32'h1);
    checkEq("R10 active10 not yet", activeDiv10, 32'h0000_021F);
    waitCycles(1);
    rdReg(8'h28, v); checkEq("R9 request not extended", v, 32'h0);
    checkEq("R10 late pending applied", activeDiv10, 32'h0000_021C);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checkCount++; failCount++;
    $display("FAIL watchdog expired actual=%0d expected=0", WATCHDOG);
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

  initial begin
    waitCycles(3);
    rstN = 1'b1;
    waitCycles(1);
    testReset();
    testAddressing();
    testFieldEnables();
    testPackedWord();
    testStagedHold();
    testCommitTiming();
    testBusyIgnore();
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

endmodule